// File: doc/BRIEF.md
# PCI System Error Reporting Logic

This block sits beside a bus bridge and turns error events into the active-low system error signal of the bus. Each clock it looks at a set of single-cycle error strobes from the bridge's transaction engines, plus a software trigger. When any qualifying condition is present it drives the system error output low for one clock. It also records the event in a sticky status bit and in interrupt status bits toward the local core.

The block keeps two kinds of system error apart: those it raises itself and those another agent raises on the shared line. A self-raised error sets the "raised" interrupt bit unless software has masked it. It also sets the "seen" interrupt bit when the seen-interrupt enable is on, so one event can set both bits. To silence the core completely for self-raised errors, software must set the mask and clear the enable. A low level on the external line, after synchronization, sets only the "seen" bit and only under the same enable. Software clears any recorded bit by writing a one to it.

Top module: `serr_report`

## Requirements
- R1: `serr_n` goes low in the clock after each cycle that has at least one qualifying condition and is high otherwise. Several conditions in the same cycle give a single one-clock low pulse.
- R2: `ev_addr_err`, `ev_msi_abort` and `ev_inb_mabort` each qualify whatever the value of `mode_ext`.
- R3: `ev_attr_err` and `ev_mdpe` qualify only while `mode_ext` is 1. With `mode_ext` 0 they change no output.
- R4: `man_assert` qualifies only while `serr_en` is 1. With `serr_en` 0 it changes no output.
- R5: `man_assert` held at 1 gives exactly one qualifying cycle. It must return to 0 before it can qualify again.
- R6: every qualifying cycle sets `stat_asserted` (status register bit 0), whatever the mask and enable inputs.
- R7: a qualifying cycle sets `isr[0]` only when `asrt_irq_mask` is 0. When the mask is 1, `isr[0]` is left unchanged.
- R8: a qualifying cycle also sets `isr[1]` when `det_irq_en` is 1.
- R9: a high-to-low transition of `ext_serr_n` sets `isr[1]` three clocks later if `det_irq_en` is 1. A low level held for many cycles counts once. With `det_irq_en` 0 the bit is left unchanged.
- R10: a write with `wr_en`=1 clears each bit whose `wr_data` bit is 1: `wr_sel`=0 addresses the status register (bit 0 = `stat_asserted`), and `wr_sel`=1 addresses the interrupt status register (bit 0 raised, bit 1 seen). A set in the same cycle wins over the clear.
- R11: `irq` is 1 exactly when either `isr` bit is 1.
- R12: during and right after reset, `serr_n` is 1 and `stat_asserted`, `isr` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_addr_err | input | 1 | Uncorrectable address error strobe |
| ev_attr_err | input | 1 | Uncorrectable attribute error strobe |
| ev_mdpe | input | 1 | Master data parity error recorded strobe |
| ev_msi_abort | input | 1 | Outbound interrupt-message write aborted strobe |
| ev_inb_mabort | input | 1 | Inbound write master-aborted on internal bus strobe |
| mode_ext | input | 1 | 1 = extended bus mode |
| man_assert | input | 1 | Software manual trigger level |
| serr_en | input | 1 | System error drive enable for the manual trigger |
| asrt_irq_mask | input | 1 | 1 masks the raised interrupt bit |
| det_irq_en | input | 1 | 1 enables the seen interrupt bit |
| ext_serr_n | input | 1 | Sampled external system error line, active low |
| wr_en | input | 1 | Clear write strobe |
| wr_sel | input | 1 | 0 = status, 1 = interrupt status |
| wr_data | input | 2 | Write-one-to-clear data |
| serr_n | output | 1 | System error drive, active low |
| stat_asserted | output | 1 | Sticky raised status bit |
| isr | output | 2 | Interrupt status: bit 0 raised, bit 1 seen |
| irq | output | 1 | Interrupt request to the core |

## Verification
Inputs applied before an edge show their effect on `serr_n`, `stat_asserted`, `isr` and `irq` right after that edge. The one exception is the external line, which passes through two synchronizer stages and an edge register, so its effect on `isr[1]` arrives on the third edge. The bench holds each input pattern for exactly one clock. Its reference model advances once per clock and files each expected snapshot under the cycle number when it is due. A monitor at the falling clock edge compares the queue head only in that cycle. Delays are therefore tied to exact cycle counts, and a pulse one clock too early, one clock too late or two clocks long shows up as a mismatch.

// File: rtl/serr_pkg.sv
// Package: shared indices, masks and register selects of the system error
// reporting logic. Assumes event strobes are packed in the order below.
package serr_pkg;

    localparam int NUM_EVT = 5;

    // Bit position of each bridge error strobe inside the packed event vector
    localparam int EV_ADDR     = 0;
    localparam int EV_ATTR     = 1;
    localparam int EV_MDPE     = 2;
    localparam int EV_MSI_ABT  = 3;
    localparam int EV_INB_MABT = 4;

    // Events that only qualify while the bus runs in extended mode
    localparam logic [NUM_EVT-1:0] EVT_MODE_GATED =
        (NUM_EVT'(1) << EV_ATTR) | (NUM_EVT'(1) << EV_MDPE);

    // Interrupt status bit positions
    localparam int ISR_W    = 2;
    localparam int ISR_ASRT = 0;
    localparam int ISR_DET  = 1;

    // Register select for the write-one-to-clear port
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ISR    = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/serr_line_sync.sv
// Module: serr_line_sync
// Brings the external active-low system error line into the clock domain
// through SYNC_STAGES flops. One extra flop gives a one-clock pulse on each
// high-to-low transition. Assumes the idle level of the line is high.
module serr_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic fall_pulse
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the line level through the synchronizer and edge flops
    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= line_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Falling edge: synchronized level low while the older sample was high
    always_comb begin
        fall_pulse = !chain_q[SYNC_STAGES-1] && chain_q[SYNC_STAGES];
    end

endmodule

// File: rtl/serr_trigger.sv
// Module: serr_trigger
// Decides in each cycle whether the block raises system error. Mode-gated
// events qualify only in extended mode. The manual trigger qualifies once
// per 0-to-1 cycle of its level and only while the drive enable is set.
// The output pin is registered and low for one clock per qualifying cycle.
module serr_trigger
    import serr_pkg::*;
#(
    parameter int N_EVT = NUM_EVT,
    parameter logic [N_EVT-1:0] GATED = EVT_MODE_GATED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic             mode_ext,
    input  logic             man_req,
    input  logic             drive_en,
    output logic             hw_hit,
    output logic             fire,
    output logic             serr_n
);
    logic [N_EVT-1:0] evt_ok;
    logic             man_armed_q;
    logic             man_fire;
    logic             serr_n_q;

    // Qualify each event; mode-gated ones need extended mode
    generate
        for (genvar i = 0; i < N_EVT; i++) begin : g_qual
            if (GATED[i]) begin : g_gated
                always_comb evt_ok[i] = evt[i] && mode_ext;
            end else begin : g_plain
                always_comb evt_ok[i] = evt[i];
            end
        end
    endgenerate

    // Combine hardware events and the armed manual trigger
    always_comb begin
        hw_hit   = |evt_ok;
        man_fire = man_req && drive_en && man_armed_q;
        fire     = hw_hit || man_fire;
    end

    // Disarm after a manual fire, re-arm once software drops the level
    always_ff @(posedge clk) begin
        if (!rst_n)         man_armed_q <= 1'b1;
        else if (man_fire)  man_armed_q <= 1'b0;
        else if (!man_req)  man_armed_q <= 1'b1;
    end

    // Register the active-low drive so each qualifying cycle gives one low clock
    always_ff @(posedge clk) begin
        if (!rst_n) serr_n_q <= 1'b1;
        else        serr_n_q <= !fire;
    end

    assign serr_n = serr_n_q;

endmodule

// File: rtl/serr_status.sv
// Module: serr_status
// Holds the sticky raised status bit and the two interrupt status bits.
// All are write-one-to-clear, and a set in the same cycle wins. Assumes
// self_fire and ext_fall are single-cycle pulses.
module serr_status
    import serr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             self_fire,
    input  logic             ext_fall,
    input  logic             asrt_mask,
    input  logic             det_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [ISR_W-1:0] wr_data,
    output logic             stat_asserted,
    output logic [ISR_W-1:0] isr,
    output logic             irq
);
    logic             stat_q;
    logic [ISR_W-1:0] isr_q;
    logic             stat_clr;
    logic [ISR_W-1:0] isr_clr;
    logic [ISR_W-1:0] isr_set;

    // Decode clear strobes from the write port
    always_comb begin
        stat_clr = wr_en && (wr_sel == SEL_STATUS) && wr_data[0];
        isr_clr  = (wr_en && (wr_sel == SEL_ISR)) ? wr_data : '0;
    end

    // Work out which interrupt status bits the events set
    always_comb begin
        isr_set           = '0;
        isr_set[ISR_ASRT] = self_fire && !asrt_mask;
        isr_set[ISR_DET]  = (self_fire || ext_fall) && det_en;
    end

    // Sticky raised status: set on every self fire, clear on write-one
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= self_fire || (stat_q && !stat_clr);
    end

    // Interrupt status bits with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_set | (isr_q & ~isr_clr);
    end

    // Drive outputs; the core request is any pending interrupt status
    always_comb begin
        stat_asserted = stat_q;
        isr           = isr_q;
        irq           = |isr_q;
    end

endmodule

// File: rtl/serr_report.sv
// Module: serr_report (top)
// System error reporting for a bus bridge: packs the bridge's error strobes,
// decides when to raise the active-low system error pin, synchronizes the
// shared external line, and keeps the status and interrupt status bits.
// Assumes event strobes are synchronous and one cycle wide.
module serr_report
    import serr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_addr_err,
    input  logic       ev_attr_err,
    input  logic       ev_mdpe,
    input  logic       ev_msi_abort,
    input  logic       ev_inb_mabort,
    input  logic       mode_ext,
    input  logic       man_assert,
    input  logic       serr_en,
    input  logic       asrt_irq_mask,
    input  logic       det_irq_en,
    input  logic       ext_serr_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [1:0] wr_data,
    output logic       serr_n,
    output logic       stat_asserted,
    output logic [1:0] isr,
    output logic       irq
);
    logic [NUM_EVT-1:0] evt_vec;
    logic               hw_hit;
    logic               fire;
    logic               ext_fall;

    // Pack the bridge strobes in package order
    always_comb begin
        evt_vec              = '0;
        evt_vec[EV_ADDR]     = ev_addr_err;
        evt_vec[EV_ATTR]     = ev_attr_err;
        evt_vec[EV_MDPE]     = ev_mdpe;
        evt_vec[EV_MSI_ABT]  = ev_msi_abort;
        evt_vec[EV_INB_MABT] = ev_inb_mabort;
    end

    serr_trigger #(
        .N_EVT (NUM_EVT),
        .GATED (EVT_MODE_GATED)
    ) u_trigger (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_vec),
        .mode_ext (mode_ext),
        .man_req  (man_assert),
        .drive_en (serr_en),
        .hw_hit   (hw_hit),
        .fire     (fire),
        .serr_n   (serr_n)
    );

    serr_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_line_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_n     (ext_serr_n),
        .fall_pulse (ext_fall)
    );

    serr_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .self_fire     (fire),
        .ext_fall      (ext_fall),
        .asrt_mask     (asrt_irq_mask),
        .det_en        (det_irq_en),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .stat_asserted (stat_asserted),
        .isr           (isr),
        .irq           (irq)
    );

endmodule

// File: rtl/serr_report_chk.sv
// Module: serr_report_chk
// Property checker for serr_report, attached by bind below. Relates the
// output pin, the status bits and the control inputs across clocks.
module serr_report_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       serr_en,
    input logic       asrt_irq_mask,
    input logic       det_irq_en,
    input logic       hw_hit,
    input logic       serr_n,
    input logic       stat_asserted,
    input logic [1:0] isr
);
    // R6: a low pin is always recorded in the sticky status bit
    assert_stat_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> stat_asserted);

    // R4: a pulse with no hardware cause needs the drive enable
    assert_manual_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!serr_n && !$past(hw_hit)) |-> $past(serr_en));

    // R7: with the mask set, a clear raised bit stays clear
    assert_mask_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(asrt_irq_mask) && !$past(isr[0])) |-> !isr[0]);

    // R8: a self pulse under the seen enable sets the seen bit
    assert_self_sets_det_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!serr_n && $past(det_irq_en)) |-> isr[1]);

    // R9: the seen bit only rises while its enable was on
    assert_det_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr[1]) |-> $past(det_irq_en));
endmodule

bind serr_report serr_report_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .serr_en       (serr_en),
    .asrt_irq_mask (asrt_irq_mask),
    .det_irq_en    (det_irq_en),
    .hw_hit        (hw_hit),
    .serr_n        (serr_n),
    .stat_asserted (stat_asserted),
    .isr           (isr)
);

// File: tb/serr_report_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver applies one input pattern per clock, a
// reference model pushes the expected outputs due after that edge, and a
// monitor at the falling edge pops and compares them.
module serr_report_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_addr_err = 0, ev_attr_err = 0, ev_mdpe = 0;
    logic       ev_msi_abort = 0, ev_inb_mabort = 0;
    logic       mode_ext = 0, man_assert = 0, serr_en = 0;
    logic       asrt_irq_mask = 0, det_irq_en = 0, ext_serr_n = 1;
    logic       wr_en = 0, wr_sel = 0;
    logic [1:0] wr_data = 0;
    logic       serr_n, stat_asserted, irq;
    logic [1:0] isr;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int        due;
        string     tag;
        logic      serr_n;
        logic      stat;
        logic [1:0] isr;
        logic      irq;
    } exp_t;
    exp_t sb_q[$];

    // Reference model state
    logic m_stat = 0, m_armed = 1;
    logic [1:0] m_isr = 0;
    logic m_e0 = 1, m_e1 = 1, m_e2 = 1;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serr_report u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_addr_err(ev_addr_err), .ev_attr_err(ev_attr_err), .ev_mdpe(ev_mdpe),
        .ev_msi_abort(ev_msi_abort), .ev_inb_mabort(ev_inb_mabort),
        .mode_ext(mode_ext), .man_assert(man_assert), .serr_en(serr_en),
        .asrt_irq_mask(asrt_irq_mask), .det_irq_en(det_irq_en),
        .ext_serr_n(ext_serr_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .serr_n(serr_n), .stat_asserted(stat_asserted), .isr(isr), .irq(irq)
    );

    // Monitor: compare the queue head in the cycle it is due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (e.due != cyc || serr_n !== e.serr_n || stat_asserted !== e.stat ||
                isr !== e.isr || irq !== e.irq) begin
                n_bad++;
                $display("FAIL %s cyc %0d: actual serr_n=%b stat=%b isr=%b irq=%b expected serr_n=%b stat=%b isr=%b irq=%b",
                         e.tag, cyc, serr_n, stat_asserted, isr, irq,
                         e.serr_n, e.stat, e.isr, e.irq);
            end
        end
    end

    // Driver: model one edge from the current inputs, push the result, advance
    task automatic tick(input string tag);
        exp_t e;
        logic hw, mf, a, fall, sclr;
        logic [1:0] iclr, iset;
        if (!rst_n) begin
            m_stat = 0; m_isr = 0; m_armed = 1;
            m_e0 = 1; m_e1 = 1; m_e2 = 1; a = 0;
        end else begin
            hw = ev_addr_err | ev_msi_abort | ev_inb_mabort |
                 (mode_ext & (ev_attr_err | ev_mdpe));              // R2, R3
            mf = man_assert & serr_en & m_armed;                   // R4
            if (mf) m_armed = 0; else if (!man_assert) m_armed = 1; // R5
            a = hw | mf;
            fall = !m_e1 & m_e2;                                   // R9
            m_e2 = m_e1; m_e1 = m_e0; m_e0 = ext_serr_n;
            sclr = wr_en & !wr_sel & wr_data[0];                   // R10
            iclr = (wr_en & wr_sel) ? wr_data : 2'b00;
            iset = {(a | fall) & det_irq_en, a & !asrt_irq_mask}; // R7, R8
            m_stat = a | (m_stat & !sclr);                         // R6
            m_isr  = iset | (m_isr & ~iclr);
        end
        e.due = cyc + 1; e.tag = tag;
        e.serr_n = !a; e.stat = m_stat; e.isr = m_isr; e.irq = |m_isr; // R1, R11
        sb_q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic clr_all(input string tag);
        wr_en = 1; wr_sel = 0; wr_data = 2'b01; tick(tag);
        wr_sel = 1; wr_data = 2'b11; tick(tag);
        wr_en = 0; wr_data = 0;
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        tick("R12 reset"); tick("R12 reset"); tick("R12 reset");
        rst_n = 1;
        tick("R12 idle after reset");

        // R2: mode-free events, one at a time, mode off
        ev_addr_err = 1;   tick("R2 addr");   ev_addr_err = 0;   tick("R1 pulse ends");
        ev_msi_abort = 1;  tick("R2 msi");    ev_msi_abort = 0;  tick("R1 pulse ends");
        ev_inb_mabort = 1; tick("R2 inb");    ev_inb_mabort = 0; tick("R1 pulse ends");
        clr_all("R10 clear");

        // R3: mode-gated events
        ev_attr_err = 1; tick("R3 attr mode0"); ev_attr_err = 0;
        ev_mdpe = 1;     tick("R3 mdpe mode0"); ev_mdpe = 0; tick("R3 idle");
        mode_ext = 1;
        ev_attr_err = 1; tick("R3 attr mode1"); ev_attr_err = 0; tick("R1 idle");
        ev_mdpe = 1;     tick("R3 mdpe mode1"); ev_mdpe = 0; tick("R1 idle");

        // R1: coincident events then back-to-back events
        ev_addr_err = 1; ev_attr_err = 1; ev_mdpe = 1; ev_msi_abort = 1; ev_inb_mabort = 1;
        tick("R1 coincident");
        ev_attr_err = 0; ev_mdpe = 0; ev_msi_abort = 0; ev_inb_mabort = 0;
        tick("R1 back-to-back");
        ev_addr_err = 0; tick("R1 idle"); tick("R1 idle");
        clr_all("R10 clear");

        // R7, R8, R11: mask and enable combinations
        asrt_irq_mask = 1; det_irq_en = 0;
        ev_addr_err = 1; tick("R7 masked silent"); ev_addr_err = 0; tick("R11 no irq");
        det_irq_en = 1;
        ev_addr_err = 1; tick("R8 det via self"); ev_addr_err = 0; tick("R11 irq");
        clr_all("R10 clear");
        asrt_irq_mask = 0;
        ev_msi_abort = 1; tick("R8 both bits"); ev_msi_abort = 0; tick("R11 irq");
        det_irq_en = 0;
        clr_all("R10 clear");

        // R4, R5: manual trigger
        man_assert = 1; serr_en = 0; tick("R4 disabled"); tick("R4 disabled");
        serr_en = 1; tick("R4 enabled fires");
        tick("R5 held"); tick("R5 held"); tick("R5 held");
        man_assert = 0; tick("R5 rearm");
        man_assert = 1; tick("R5 fires again"); tick("R5 held");
        man_assert = 0; serr_en = 0; tick("R5 idle");
        clr_all("R10 clear");

        // R10: set wins over clear in the same cycle
        ev_addr_err = 1; wr_en = 1; wr_sel = 0; wr_data = 2'b01;
        tick("R10 set beats status clear");
        wr_sel = 1; wr_data = 2'b01; tick("R10 set beats isr clear");
        ev_addr_err = 0; wr_en = 0; wr_data = 0; tick("R10 after");
        wr_en = 1; wr_sel = 1; wr_data = 2'b10; tick("R10 clear unset bit only");
        wr_en = 0; wr_data = 0;
        clr_all("R10 clear");

        // R9: external line low with and without enable
        det_irq_en = 1; ext_serr_n = 0;
        for (int i = 0; i < 6; i++) tick("R9 ext low held");
        ext_serr_n = 1; tick("R9 ext high"); tick("R9 ext high");
        clr_all("R10 clear");
        for (int i = 0; i < 4; i++) tick("R9 held once");
        det_irq_en = 0; ext_serr_n = 0;
        for (int i = 0; i < 5; i++) tick("R9 disabled");
        ext_serr_n = 1;
        for (int i = 0; i < 4; i++) tick("R9 idle");

        // R12: reset again from a busy state
        ev_addr_err = 1; tick("R6 before reset"); ev_addr_err = 0;
        rst_n = 0; tick("R12 reset again"); rst_n = 1; tick("R12 out of reset");

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule